// File: doc/BRIEF.md
# Two-Bank Calibrated Register File for a 40-Channel DAC

This block holds the digital state of a 40-channel DAC. The channels form five groups of eight. Each channel keeps a gain word and an offset word, plus two calibrated value registers, bank A and bank B. A host write of channel data passes through a shared calibration stage. The stage multiplies the input by the gain, adds the offset and saturates the result. The result goes into the bank that one global control bit names. Each channel has a bank-select bit that chooses which calibrated register feeds its DAC output register. The output registers change only on a load strobe.

A common use keeps the normal code in bank A and a preloaded clear code in bank B. All channels can then be sent to the clear level with one select-all write and one load strobe, instead of one write per channel. Each group has a deglitch request flag. A data write to any channel of the group sets the flag, and the next load strobe clears it. Select changes leave the flag alone.

Top module: `dac_bank_regfile`

## Requirements
- R1: After reset every DAC output word is 0x0000, every deglitch flag is 0, every channel's gain is 0xFFFF and offset 0x8000 (so calibration passes data through unchanged), every select bit picks bank A, and the global write bank is A.
- R2: A write with kind 0 (data) to a channel address 0..39 stores the calibrated value in bank A when the global bank bit is 0, and in bank B when it is 1. The other bank keeps its value.
- R3: The stored value is floor(x*(gain+1)/65536) + offset - 32768, clamped to 0..65535.
- R4: A write with kind 1 sets the addressed channel's gain and kind 2 sets its offset. They take effect for later data writes only and do not change values already stored.
- R5: Outputs change only on a cycle with `ldac` high. On that edge each channel loads its selected bank: bank A when its select bit is 0, bank B when it is 1.
- R6: A write with kind 3 to address g (0..4) loads the select bits of group g from wr_data[7:0]. Bit i belongs to channel 8*g+i.
- R7: A write with kind 3 to address 49 sets every channel's select bit to wr_data[0] in one write. A write with kind 3 to address 48 sets the global bank bit to wr_data[0].
- R8: A data write to a channel sets the deglitch flag of group (address/8). A load strobe clears all flags, except that a data write in the same cycle as the strobe leaves its own group's flag set.
- R9: Select, control, gain and offset writes never set a deglitch flag.
- R10: A write of kind 0, 1 or 2 to an address of 40 or more is ignored. So is a kind 3 write to any address other than 0..4, 48 or 49.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_kind | input | 2 | 0 data, 1 gain, 2 offset, 3 select/control |
| wr_addr | input | 6 | Channel, group or control address |
| wr_data | input | 16 | Write data |
| ldac | input | 1 | Load strobe for the DAC output registers |
| dac_out | output | 640 | DAC output words, channel n at bits [16n+15:16n] |
| deglitch_req | output | 5 | Per-group deglitch request flags |

## Verification
Calibration is tried with the reset gain and offset, which pass data through and so separate bank routing from arithmetic. A halved gain shows whether the product is shifted correctly. A large offset drives the result above full scale and a zero offset drives it below zero, which exercises each saturation limit separately. Bank routing is told apart by writing different codes to A and B of the same channel and then switching the select bit three ways: per group, all at once, and not at all. The deglitch flags are tried with writes to different groups, with a write that lands on the same cycle as a load strobe, and with select and out-of-range writes, which must leave every output and flag unchanged.

// File: rtl/dac_rf_pkg.sv
// Package: shared write-kind encoding for the DAC register file.
// Assumes a 2-bit kind field on the host write port.
package dac_rf_pkg;
    typedef enum logic [1:0] {
        WK_DATA = 2'd0,
        WK_GAIN = 2'd1,
        WK_OFFS = 2'd2,
        WK_CTRL = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/dac_cal_unit.sv
// Module: combinational gain/offset calibration.
// Computes floor(x*(m+1)/2^W) + c - 2^(W-1), clamped to 0..2^W-1.
// Assumes unsigned inputs; one instance is shared by all channels.
module dac_cal_unit #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] gain,
    input  logic [DATA_W-1:0] offs,
    output logic [DATA_W-1:0] y_out
);
    localparam int PW = 2 * DATA_W + 1;
    localparam int SW = DATA_W + 3;
    localparam logic [SW-1:0] HALF = SW'(1) << (DATA_W - 1);

    logic [DATA_W:0]   gain_p1;
    logic [PW-1:0]     prod;
    logic [DATA_W:0]   scaled;
    logic [SW-1:0]     sum;
    logic              unused_lsb;

    assign gain_p1    = {1'b0, gain} + {{DATA_W{1'b0}}, 1'b1};
    assign prod       = {{(DATA_W + 1){1'b0}}, x_in} * {{DATA_W{1'b0}}, gain_p1};
    assign scaled     = prod[PW-1:DATA_W];
    assign unused_lsb = ^prod[DATA_W-1:0];
    assign sum        = {2'b00, scaled} + {3'b000, offs} - HALF;

    // Clamp the signed sum into the unsigned output range.
    always_comb begin
        if (sum[SW-1])
            y_out = '0;
        else if (|sum[SW-2:DATA_W])
            y_out = '1;
        else
            y_out = sum[DATA_W-1:0];
    end
endmodule

// File: rtl/dac_channel.sv
// Module: one channel's storage: gain, offset, two calibrated banks,
// bank-select bit and the DAC output register.
// Assumes the calibrated value is produced outside and valid with data_we.
module dac_channel #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_we,
    input  logic              bank_b,
    input  logic              gain_we,
    input  logic              offs_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cal_val,
    input  logic              sel_we,
    input  logic              sel_val,
    input  logic              ldac,
    output logic [DATA_W-1:0] gain_q,
    output logic [DATA_W-1:0] offs_q,
    output logic [DATA_W-1:0] dac_q
);
    localparam logic [DATA_W-1:0] GAIN_RST = '1;
    localparam logic [DATA_W-1:0] OFFS_RST = DATA_W'(1) << (DATA_W - 1);

    logic [DATA_W-1:0] bank_a_q;
    logic [DATA_W-1:0] bank_b_q;
    logic              sel_q;

    // Register updates: trim words, banks, select and output load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gain_q   <= GAIN_RST;
            offs_q   <= OFFS_RST;
            bank_a_q <= '0;
            bank_b_q <= '0;
            sel_q    <= 1'b0;
            dac_q    <= '0;
        end else begin
            if (gain_we) gain_q <= wdata;
            if (offs_we) offs_q <= wdata;
            if (data_we && !bank_b) bank_a_q <= cal_val;
            if (data_we && bank_b)  bank_b_q <= cal_val;
            if (sel_we) sel_q <= sel_val;
            if (ldac) dac_q <= sel_q ? bank_b_q : bank_a_q;
        end
    end
endmodule

// File: rtl/dac_deglitch_ctrl.sv
// Module: per-group deglitch request flags.
// Set by a data write into the group, cleared by the load strobe;
// a set arriving with the strobe wins.
module dac_deglitch_ctrl #(
    parameter int NUM_GROUPS = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_GROUPS-1:0] set_vec,
    input  logic                  ldac,
    output logic [NUM_GROUPS-1:0] req
);
    // Flag register: clear on strobe, accumulate sets otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req <= '0;
        else if (ldac)
            req <= set_vec;
        else
            req <= req | set_vec;
    end
endmodule

// File: rtl/dac_bank_regfile.sv
// Module: top of the two-bank DAC register file.
// Decodes host writes, shares one calibration unit across channels,
// holds the global write-bank bit and drives the deglitch flags.
// Assumes at most one write per cycle; the write and ldac may coincide.
module dac_bank_regfile #(
    parameter int NUM_GROUPS = 5,
    parameter int GROUP_SIZE = 8,
    parameter int DATA_W     = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [1:0]                        wr_kind,
    input  logic [$clog2(NUM_GROUPS*GROUP_SIZE+16)-1:0] wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic                              ldac,
    output logic [NUM_GROUPS*GROUP_SIZE*DATA_W-1:0] dac_out,
    output logic [NUM_GROUPS-1:0]             deglitch_req
);
    import dac_rf_pkg::*;

    localparam int NUM_CH = NUM_GROUPS * GROUP_SIZE;
    localparam int ADDR_W = $clog2(NUM_CH + 16);
    localparam logic [ADDR_W-1:0] BANK_ADDR   = ADDR_W'(NUM_CH + 8);
    localparam logic [ADDR_W-1:0] SELALL_ADDR = ADDR_W'(NUM_CH + 9);

    logic              addr_is_ch;
    logic              data_hit, gain_hit, offs_hit;
    logic              grp_sel_hit, selall_hit, bank_hit;
    logic              bank_q;
    logic [ADDR_W-1:0] ch_idx;
    logic [DATA_W-1:0] gain_arr [NUM_CH];
    logic [DATA_W-1:0] offs_arr [NUM_CH];
    logic [DATA_W-1:0] cal_val;
    logic [NUM_GROUPS-1:0] set_vec;

    // Write decode by kind and address range.
    always_comb begin
        addr_is_ch  = (wr_addr < ADDR_W'(NUM_CH));
        data_hit    = wr_en && (wr_kind == WK_DATA) && addr_is_ch;
        gain_hit    = wr_en && (wr_kind == WK_GAIN) && addr_is_ch;
        offs_hit    = wr_en && (wr_kind == WK_OFFS) && addr_is_ch;
        grp_sel_hit = wr_en && (wr_kind == WK_CTRL) && (wr_addr < ADDR_W'(NUM_GROUPS));
        selall_hit  = wr_en && (wr_kind == WK_CTRL) && (wr_addr == SELALL_ADDR);
        bank_hit    = wr_en && (wr_kind == WK_CTRL) && (wr_addr == BANK_ADDR);
        ch_idx      = addr_is_ch ? wr_addr : '0;
    end

    // Global write-bank bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= 1'b0;
        else if (bank_hit)
            bank_q <= wr_data[0];
    end

    dac_cal_unit #(.DATA_W(DATA_W)) u_cal (
        .x_in  (wr_data),
        .gain  (gain_arr[ch_idx]),
        .offs  (offs_arr[ch_idx]),
        .y_out (cal_val)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign set_vec[g] = data_hit && (wr_addr >= ADDR_W'(g * GROUP_SIZE))
                                     && (wr_addr <  ADDR_W'((g + 1) * GROUP_SIZE));
        for (genvar i = 0; i < GROUP_SIZE; i++) begin : g_ch
            localparam int CH = g * GROUP_SIZE + i;
            logic this_ch;
            logic sel_we;
            logic sel_val;
            assign this_ch = (wr_addr == ADDR_W'(CH));
            assign sel_we  = selall_hit || (grp_sel_hit && (wr_addr == ADDR_W'(g)));
            assign sel_val = selall_hit ? wr_data[0] : wr_data[i];

            dac_channel #(.DATA_W(DATA_W)) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .data_we (data_hit && this_ch),
                .bank_b  (bank_q),
                .gain_we (gain_hit && this_ch),
                .offs_we (offs_hit && this_ch),
                .wdata   (wr_data),
                .cal_val (cal_val),
                .sel_we  (sel_we),
                .sel_val (sel_val),
                .ldac    (ldac),
                .gain_q  (gain_arr[CH]),
                .offs_q  (offs_arr[CH]),
                .dac_q   (dac_out[CH*DATA_W +: DATA_W])
            );
        end
    end

    dac_deglitch_ctrl #(.NUM_GROUPS(NUM_GROUPS)) u_dg (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .ldac    (ldac),
        .req     (deglitch_req)
    );
endmodule

// File: rtl/dac_bank_regfile_chk.sv
// Module: property checker bound to dac_bank_regfile.
// Observes only the top-level ports.
module dac_bank_regfile_chk #(
    parameter int NUM_GROUPS = 5,
    parameter int GROUP_SIZE = 8,
    parameter int DATA_W     = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [1:0]                        wr_kind,
    input  logic [$clog2(NUM_GROUPS*GROUP_SIZE+16)-1:0] wr_addr,
    input  logic                              ldac,
    input  logic [NUM_GROUPS*GROUP_SIZE*DATA_W-1:0] dac_out,
    input  logic [NUM_GROUPS-1:0]             deglitch_req
);
    localparam int NUM_CH = NUM_GROUPS * GROUP_SIZE;

    logic data_wr;
    int   grp_now;
    assign data_wr = wr_en && (wr_kind == 2'd0) && (int'(wr_addr) < NUM_CH);
    assign grp_now = data_wr ? int'(wr_addr) / GROUP_SIZE : 0;

    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ldac |=> $stable(dac_out)); // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac && !data_wr) |=> (deglitch_req == '0)); // R8
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> deglitch_req[$past(grp_now)]); // R8
    AST_NO_FLAG_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_wr && !ldac && deglitch_req == '0) |=> (deglitch_req == '0)); // R9
endmodule

bind dac_bank_regfile dac_bank_regfile_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_SIZE (GROUP_SIZE),
    .DATA_W     (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_kind      (wr_kind),
    .wr_addr      (wr_addr),
    .ldac         (ldac),
    .dac_out      (dac_out),
    .deglitch_req (deglitch_req)
);

// File: tb/tb_dac_bank_regfile.sv
// Directed bench for dac_bank_regfile: one task per scenario.
module tb_dac_bank_regfile;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_kind = 2'd0;
    logic [5:0]   wr_addr = 6'd0;
    logic [15:0]  wr_data = 16'd0;
    logic         ldac = 1'b0;
    logic [639:0] dac_out;
    logic [4:0]   deglitch_req;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    dac_bank_regfile dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind),
        .wr_addr(wr_addr), .wr_data(wr_data), .ldac(ldac),
        .dac_out(dac_out), .deglitch_req(deglitch_req)
    );

    function automatic logic [15:0] cal(input logic [15:0] x, input logic [15:0] m,
                                        input logic [15:0] c);
        longint v;
        v = (longint'(x) * (longint'(m) + 1)) / 65536 + longint'(c) - 32768;
        if (v < 0) return 16'h0000;
        if (v > 65535) return 16'hFFFF;
        return v[15:0];
    endfunction

    function automatic logic [15:0] ch(input int n);
        return dac_out[n*16 +: 16];
    endfunction

    task automatic check(input string req, input logic [639:0] act, input logic [639:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] k, input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_addr = 6'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load();
        @(negedge clk);
        ldac = 1'b1;
        @(negedge clk);
        ldac = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 dac_out", dac_out, '0);
        check("R1 deglitch", 640'(deglitch_req), 640'(0));
    endtask

    task automatic t_basic();
        wr(2'd0, 3, 16'h1234);
        check("R5 no load yet", 640'(ch(3)), 640'(0));
        check("R8 flag set", 640'(deglitch_req), 640'(5'b00001));
        load();
        check("R2 bank A identity", 640'(ch(3)), 640'(16'h1234));
        check("R8 flag clear", 640'(deglitch_req), 640'(0));
    endtask

    task automatic t_bank_b();
        wr(2'd3, 48, 16'h0001);
        check("R9 ctrl no flag", 640'(deglitch_req), 640'(0));
        wr(2'd0, 3, 16'hABCD);
        load();
        check("R2 bank B not selected", 640'(ch(3)), 640'(16'h1234));
        wr(2'd3, 0, 16'h0008);
        check("R9 select no flag", 640'(deglitch_req), 640'(0));
        load();
        check("R6 group select bit3", 640'(ch(3)), 640'(16'hABCD));
        check("R6 other channel A", 640'(ch(2)), 640'(0));
    endtask

    task automatic t_select_all();
        wr(2'd0, 17, 16'h5555);
        wr(2'd3, 48, 16'h0000);
        wr(2'd0, 17, 16'h2222);
        wr(2'd3, 49, 16'h0001);
        load();
        check("R7 all B ch17", 640'(ch(17)), 640'(16'h5555));
        check("R7 all B ch3", 640'(ch(3)), 640'(16'hABCD));
        wr(2'd3, 49, 16'h0000);
        load();
        check("R7 all A ch17", 640'(ch(17)), 640'(16'h2222));
        check("R7 all A ch3", 640'(ch(3)), 640'(16'h1234));
    endtask

    task automatic t_cal();
        wr(2'd1, 9, 16'h7FFF);
        load();
        check("R4 gain write no effect", 640'(ch(9)), 640'(0));
        wr(2'd0, 9, 16'h1000);
        load();
        check("R3 half gain", 640'(ch(9)), 640'(cal(16'h1000, 16'h7FFF, 16'h8000)));
        wr(2'd2, 9, 16'hFFFF);
        wr(2'd0, 9, 16'hF000);
        load();
        check("R3 offset add", 640'(ch(9)), 640'(cal(16'hF000, 16'h7FFF, 16'hFFFF)));
        wr(2'd1, 9, 16'hFFFF);
        wr(2'd0, 9, 16'hF000);
        load();
        check("R3 saturate high", 640'(ch(9)), 640'(16'hFFFF));
        wr(2'd2, 9, 16'h0000);
        wr(2'd0, 9, 16'h1000);
        load();
        check("R3 saturate low", 640'(ch(9)), 640'(16'h0000));
        check("R4 other channel untouched", 640'(ch(8)), 640'(0));
    endtask

    task automatic t_deglitch();
        wr(2'd0, 35, 16'h0100);
        wr(2'd0, 0, 16'h0200);
        check("R8 two groups", 640'(deglitch_req), 640'(5'b10001));
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 2'd0; wr_addr = 6'd20; wr_data = 16'h0300; ldac = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ldac = 1'b0;
        check("R8 write with strobe", 640'(deglitch_req), 640'(5'b00100));
        check("R5 strobe uses old bank", 640'(ch(20)), 640'(0));
        load();
        check("R8 cleared", 640'(deglitch_req), 640'(0));
        check("R5 loaded later", 640'(ch(20)), 640'(16'h0300));
    endtask

    task automatic t_out_of_range();
        logic [639:0] snap;
        snap = dac_out;
        wr(2'd0, 40, 16'h7777);
        wr(2'd0, 63, 16'h7777);
        wr(2'd1, 45, 16'h0000);
        wr(2'd3, 5, 16'hFFFF);
        wr(2'd3, 50, 16'hFFFF);
        check("R10 no flag", 640'(deglitch_req), 640'(0));
        load();
        check("R10 outputs unchanged", dac_out, snap);
        wr(2'd0, 39, 16'h4321);
        load();
        check("R10 last channel valid", 640'(ch(39)), 640'(16'h4321));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_bank_b();
        t_select_all();
        t_cal();
        t_deglitch();
        t_out_of_range();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule